// File: doc/BRIEF.md
# Gate Driver Command and Protection Core

This block is the digital control core of a low-side power switch gate driver. It takes two logic-level command inputs, one active high and one active low, and merges them into a single drive request. A request reaches the drive output only while the positive supply is reported good and the negative rail is reported good. The negative rail counts as good once it reaches 80% of its programmed level, and its flag is ignored in the mode where the charge pump is switched off. Thermal shutdown must also be inactive, and no desaturation fault may be held for the present pulse.

After the supply conditions become good, the block stays quiet until the next clean active edge of the request, so it never starts switching partway through a pulse. Once the switch is on, the desaturation flag is ignored for a fixed blanking window. After that window a desaturation flag cuts the pulse short, and the output stays off until the request goes low. A status output always shows the true drive state, high while the switch is off. Comparators, thresholds and power stages lie outside the block and arrive only as digital flags. Every asynchronous input passes through a two-flop synchronizer.

Top module: `gate_drive_ctrl`

## Requirements
- R1: The drive request is active only when `cmd_pos_i`=1 and `cmd_neg_i`=0; the other three combinations keep `drive_o` at 0.
- R2: After reset, and while the inputs rest at their idle levels (`cmd_pos_i`=0, `cmd_neg_i`=1), `drive_o`=0 and `off_flag_o`=1.
- R3: `drive_o` can be 1 only while both `vdd_ok_i`=1 and `vee_ok_i`=1 (the latter unless R4 applies).
- R4: While `pump_off_i`=1, `vee_ok_i` is ignored and only `vdd_ok_i` and thermal shutdown gate the output.
- R5: When the supplies become good while the request is already active, `drive_o` stays 0 until the request goes inactive and then makes a fresh rising transition.
- R6: In inverting use, with `cmd_pos_i` held 1, a falling edge of `cmd_neg_i` starts a pulse and a rising edge ends it.
- R7: For the first BLANK_CYC clock cycles of every on-time (50 cycles by default, 500 ns at 100 MHz), `desat_i` has no effect on `drive_o`.
- R8: After blanking, `desat_i`=1 turns `drive_o` off, and it stays off for the rest of that request even after `desat_i` returns low. The next request after the command goes low drives normally.
- R9: `therm_sd_i`=1, or the loss of a supply-good flag, forces `drive_o` to 0. After recovery, `drive_o` stays 0 until a fresh rising transition of the request.
- R10: `off_flag_o` is the complement of `drive_o` at all times, whatever the command inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_pos_i | input | 1 | Non-inverting command (PWM or enable) |
| cmd_neg_i | input | 1 | Inverting command (PWM or disable) |
| vdd_ok_i | input | 1 | Positive supply above its turn-on level |
| vee_ok_i | input | 1 | Negative rail beyond 80% of its programmed value |
| pump_off_i | input | 1 | Charge pump disabled; negative-rail flag ignored |
| therm_sd_i | input | 1 | Thermal shutdown active |
| desat_i | input | 1 | Desaturation comparator flag |
| drive_o | output | 1 | Gate drive command to the output stage |
| off_flag_o | output | 1 | High while the drive is off |

## Verification
Several functions can act in the same cycle. The desaturation flag can arrive during the blanking window, so blanking and fault termination compete. A readiness change can coincide with an active command, so arming competes with the supply check. The bench holds `desat_i` high during most of the blank window and requires that the pulse survives. It then raises the flag after the window and requires the output to fall and stay latched off. It also raises the supply flags while the request is already high and requires the output to wait for the next clean edge.

// File: rtl/gdc_pkg.sv
package gdc_pkg;

    localparam int unsigned SYNC_W   = 7;
    localparam int unsigned IX_POS   = 0;
    localparam int unsigned IX_NEG   = 1;
    localparam int unsigned IX_VDD   = 2;
    localparam int unsigned IX_VEE   = 3;
    localparam int unsigned IX_PUMP  = 4;
    localparam int unsigned IX_THERM = 5;
    localparam int unsigned IX_DESAT = 6;

    // idle levels: inverting command rests high, everything else low
    localparam logic [SYNC_W-1:0] SYNC_IDLE = 7'b000_0010;

    typedef struct packed {
        logic cmd;
        logic armed;
    } arm_state_t;

    typedef struct packed {
        logic drive;
    } top_state_t;

endpackage

// File: rtl/gdc_sync.sv
module gdc_sync #(
    parameter int unsigned         W       = 1,
    parameter logic [W-1:0]        IDLE    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_state_t;

    sync_state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = async_i;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.meta   <= IDLE;
            s_q.stable <= IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_o = s_q.stable;
endmodule

// File: rtl/gdc_arm.sv
module gdc_arm
    import gdc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_s,
    input  logic vdd_s,
    input  logic vee_s,
    input  logic pump_s,
    input  logic therm_s,
    output logic ready_o,
    output logic arm_next_o,
    output logic rise_o
);
    arm_state_t a_d, a_q;
    logic ready, rise;

    always_comb begin
        ready    = vdd_s & (vee_s | pump_s) & ~therm_s;
        rise     = cmd_s & ~a_q.cmd;
        a_d      = a_q;
        a_d.cmd  = cmd_s;
        a_d.armed = ready & (a_q.armed | rise);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end

    assign ready_o    = ready;
    assign arm_next_o = a_d.armed;
    assign rise_o     = rise;

    // arming is lost one cycle after readiness drops
    assert_disarm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> !a_q.armed);

    // a fresh arm needs a rising request edge
    assert_arm_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_q.armed) |-> ($past(cmd_s) && !$past(a_q.cmd)));
endmodule

// File: rtl/gdc_blank.sv
module gdc_blank #(
    parameter int unsigned BLANK_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drive_q,
    input  logic cmd_s,
    input  logic desat_s,
    output logic fault_next_o,
    output logic fault_o,
    output logic blank_done_o
);
    localparam int unsigned CNT_W = $clog2(BLANK_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(BLANK_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fault;
    } blank_state_t;

    blank_state_t b_d, b_q;
    logic done;

    always_comb begin
        done = (b_q.cnt == CNT_END);
        b_d  = b_q;
        if (!drive_q) begin
            b_d.cnt = '0;
        end else if (!done) begin
            b_d.cnt = b_q.cnt + 1'b1;
        end
        b_d.fault = cmd_s & (b_q.fault | (drive_q & done & desat_s));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign fault_next_o = b_d.fault;
    assign fault_o      = b_q.fault;
    assign blank_done_o = done;

    assert_no_trip_in_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_q && !done && !b_q.fault) |=> !b_q.fault);

    assert_fault_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_s |=> !b_q.fault);
endmodule

// File: rtl/gate_drive_ctrl.sv
module gate_drive_ctrl
    import gdc_pkg::*;
#(
    parameter int unsigned BLANK_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_pos_i,
    input  logic cmd_neg_i,
    input  logic vdd_ok_i,
    input  logic vee_ok_i,
    input  logic pump_off_i,
    input  logic therm_sd_i,
    input  logic desat_i,
    output logic drive_o,
    output logic off_flag_o
);
    logic [SYNC_W-1:0] raw, syn;
    logic cmd_s, ready, arm_next, rise, fault_next, fault_q, blank_done;
    top_state_t t_d, t_q;

    assign raw[IX_POS]   = cmd_pos_i;
    assign raw[IX_NEG]   = cmd_neg_i;
    assign raw[IX_VDD]   = vdd_ok_i;
    assign raw[IX_VEE]   = vee_ok_i;
    assign raw[IX_PUMP]  = pump_off_i;
    assign raw[IX_THERM] = therm_sd_i;
    assign raw[IX_DESAT] = desat_i;

    gdc_sync #(.W(SYNC_W), .IDLE(SYNC_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw), .sync_o(syn)
    );

    assign cmd_s = syn[IX_POS] & ~syn[IX_NEG];

    gdc_arm u_arm (
        .clk(clk), .rst_n(rst_n), .cmd_s(cmd_s),
        .vdd_s(syn[IX_VDD]), .vee_s(syn[IX_VEE]), .pump_s(syn[IX_PUMP]),
        .therm_s(syn[IX_THERM]),
        .ready_o(ready), .arm_next_o(arm_next), .rise_o(rise)
    );

    gdc_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
        .clk(clk), .rst_n(rst_n), .drive_q(t_q.drive), .cmd_s(cmd_s),
        .desat_s(syn[IX_DESAT]), .fault_next_o(fault_next),
        .fault_o(fault_q), .blank_done_o(blank_done)
    );

    always_comb begin
        t_d       = t_q;
        t_d.drive = arm_next & cmd_s & ~fault_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign drive_o    = t_q.drive;
    assign off_flag_o = ~t_q.drive;

    assert_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.drive |-> $past(cmd_s));

    assert_needs_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.drive |-> $past(ready));

    assert_edge_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(t_q.drive) |-> $past(rise) || !$past(fault_q));

    assert_blank_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.drive && !blank_done && cmd_s && ready) |=> t_q.drive);

    assert_fault_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_q |-> !t_q.drive);

    assert_force_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> !t_q.drive);
endmodule

// File: tb/tb_gate_drive_ctrl.sv
module tb_gate_drive_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_pos_i = 1'b0, cmd_neg_i = 1'b1;
    logic vdd_ok_i = 1'b0, vee_ok_i = 1'b0, pump_off_i = 1'b0;
    logic therm_sd_i = 1'b0, desat_i = 1'b0;
    logic drive_o, off_flag_o;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    gate_drive_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cmd_pos_i(cmd_pos_i), .cmd_neg_i(cmd_neg_i),
        .vdd_ok_i(vdd_ok_i), .vee_ok_i(vee_ok_i), .pump_off_i(pump_off_i),
        .therm_sd_i(therm_sd_i), .desat_i(desat_i),
        .drive_o(drive_o), .off_flag_o(off_flag_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_drv(input string req, input logic exp);
        checks++;
        if (drive_o !== exp || off_flag_o !== ~exp) begin
            errors++;
            $display("FAIL %s: drive=%b off_flag=%b expected drive=%b off_flag=%b",
                     req, drive_o, off_flag_o, exp, ~exp);
        end
    endtask

    task automatic t_reset_R2;
        step(2);
        expect_drv("R2 reset idle", 1'b0);
        rst_n = 1'b1;
        step(5);
        expect_drv("R2 idle after reset", 1'b0);
    endtask

    task automatic t_ready_R3_R5;
        cmd_pos_i = 1; cmd_neg_i = 0; step(5);
        expect_drv("R3 no supplies", 1'b0);
        vdd_ok_i = 1; step(5);
        expect_drv("R3 vee missing", 1'b0);
        vee_ok_i = 1; step(5);
        expect_drv("R5 no start mid pulse", 1'b0);
        cmd_pos_i = 0; step(4);
        cmd_pos_i = 1; step(4);
        expect_drv("R5 start on fresh edge", 1'b1);
        cmd_pos_i = 0; step(4);
        expect_drv("R10 off after request low", 1'b0);
    endtask

    task automatic t_truth_R1;
        cmd_pos_i = 1; cmd_neg_i = 1; step(4);
        expect_drv("R1 11", 1'b0);
        cmd_pos_i = 0; cmd_neg_i = 0; step(4);
        expect_drv("R1 00", 1'b0);
        cmd_pos_i = 0; cmd_neg_i = 1; step(4);
        expect_drv("R1 01", 1'b0);
        cmd_pos_i = 1; cmd_neg_i = 0; step(4);
        expect_drv("R1 10", 1'b1);
        cmd_pos_i = 0; step(4);
    endtask

    task automatic t_invert_R6;
        cmd_pos_i = 1; cmd_neg_i = 1; step(4);
        expect_drv("R6 enable high, neg high", 1'b0);
        cmd_neg_i = 0; step(4);
        expect_drv("R6 neg falling starts", 1'b1);
        cmd_neg_i = 1; step(4);
        expect_drv("R6 neg rising ends", 1'b0);
        cmd_pos_i = 0; step(4);
    endtask

    task automatic t_pump_R4;
        pump_off_i = 1; step(3);
        vee_ok_i = 0; step(4);
        cmd_pos_i = 1; cmd_neg_i = 0; step(4);
        expect_drv("R4 vee ignored in pump-off", 1'b1);
        cmd_pos_i = 0; step(4);
        pump_off_i = 0; step(4);
        cmd_pos_i = 1; step(4);
        expect_drv("R3 vee required again", 1'b0);
        cmd_pos_i = 0; vee_ok_i = 1; step(4);
        cmd_pos_i = 1; step(4);
        expect_drv("R9 re-armed after recovery", 1'b1);
        cmd_pos_i = 0; step(4);
    endtask

    task automatic t_blank_R7_R8;
        cmd_pos_i = 1; cmd_neg_i = 0; step(4);
        desat_i = 1; step(30);
        expect_drv("R7 desat in blank window", 1'b1);
        desat_i = 0; step(20);
        expect_drv("R7 survives past blank", 1'b1);
        desat_i = 1; step(4);
        expect_drv("R8 desat ends pulse", 1'b0);
        desat_i = 0; step(4);
        expect_drv("R8 stays off this cycle", 1'b0);
        cmd_pos_i = 0; step(4);
        cmd_pos_i = 1; step(4);
        expect_drv("R8 next cycle drives", 1'b1);
        cmd_pos_i = 0; step(4);
    endtask

    task automatic t_therm_R9;
        cmd_pos_i = 1; step(4);
        expect_drv("R9 on before shutdown", 1'b1);
        therm_sd_i = 1; step(4);
        expect_drv("R9 thermal forces off", 1'b0);
        therm_sd_i = 0; step(4);
        expect_drv("R9 waits for edge", 1'b0);
        cmd_pos_i = 0; step(4);
        cmd_pos_i = 1; step(4);
        expect_drv("R9 restart on edge", 1'b1);
        vdd_ok_i = 0; step(4);
        expect_drv("R9 vdd loss forces off", 1'b0);
        vdd_ok_i = 1; cmd_pos_i = 0; step(4);
    endtask

    initial begin
        step(1000000);
        errors++;
        checks++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset_R2();
        t_ready_R3_R5();
        t_truth_R1();
        t_invert_R6();
        t_pump_R4();
        t_blank_R7_R8();
        t_therm_R9();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule